// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic core of a DSP datapath. Two 16-bit operands go through a 17x17 multiplier. A 41-bit adder/subtracter then folds the product into one of two 40-bit accumulators, called A and B. One opcode names the operation, and a select bit picks which accumulator receives the result. The operations are plain multiply, negated multiply, multiply-accumulate, multiply-subtract, squared difference (with or without accumulate), clear, and a no-update move. Configuration inputs choose the multiply form (fractional or integer, signed or unsigned), the readout rounding style, the saturation limit, and whether saturation is enabled for accumulator A, for accumulator B and for the readout.

Some operations also produce a writeback word: clear, multiply-accumulate, multiply-subtract and move. When the writeback request is asserted with one of these, the block rounds the value held by the non-selected accumulator before the operation, saturates it if enabled, and presents it as a 16-bit word one cycle later. Every update of an accumulator also records two overflow flags. One flag marks a result that left the 32-bit range. The other marks a result that left the full 40-bit range.

Top module: `dsp_mac_engine`

## Requirements
- R1: After reset both accumulators are zero, all four overflow flags are low and `wb_valid` is low.
- R2: Opcode 0 (clear) loads zero into the selected accumulator and clears its flags. Opcode 7 (move) changes neither accumulator. An operation never changes the non-selected accumulator.
- R3: With signed integer mode, each operation updates the selected accumulator one cycle after `op_valid`. Opcode 5 loads x*y. Opcode 6 loads -(x*y). Opcode 3 adds x*y. Opcode 4 subtracts x*y.
- R4: When `cfg_signed` is 0, both operands are zero-extended to 17 bits. When it is 1, both are sign-extended.
- R5: When `cfg_frac` is 1, the product is doubled (shifted left one bit) before it reaches the adder.
- R6: Opcode 1 loads (x-y)^2. Opcode 2 adds (x-y)^2. The difference is formed from the extended operands.
- R7: When saturation is enabled for an accumulator and `cfg_sat_ext` is 0, a result outside [-2^31, 2^31-1] is clamped to the nearer limit. When saturation is disabled, the result wraps to 40 bits. The 32-bit overflow flag is set exactly when the unclamped result is outside that range.
- R8: When saturation is enabled and `cfg_sat_ext` is 1, the clamp is to the 40-bit range. The 40-bit overflow flag is set exactly when the unclamped result is outside [-2^39, 2^39-1].
- R9: `wb_valid` rises one cycle after an operation with `wb_en` for opcodes 0, 3, 4 and 7 only. `wb_data` then holds the readout of the non-selected accumulator's value from before that operation.
- R10: The readout adds 0x8000 to the accumulator and returns bits 31:16 (round half up) when `cfg_conv_rnd` is 0.
- R11: When `cfg_conv_rnd` is 1 and the low 16 bits are exactly 0x8000, the readout rounds to the even result: it adds nothing if bit 16 is 0. All other values round as in R10.
- R12: When `cfg_sat_rd` is 1, a rounded value above 2^31-1 reads as 0x7FFF and one below -2^31 reads as 0x8000. When it is 0, the readout is bits 31:16 of the rounded value.
- R13: While `op_valid` is low, neither accumulator nor any flag changes, and `wb_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Execute the operation on this edge |
| opcode | input | 3 | 0 clear, 1 sq-diff, 2 sq-diff-acc, 3 mac, 4 msc, 5 mpy, 6 neg-mpy, 7 move |
| acc_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| wb_en | input | 1 | Request readout of the other accumulator |
| cfg_frac | input | 1 | 1 = fractional multiply |
| cfg_signed | input | 1 | 1 = signed operands |
| cfg_conv_rnd | input | 1 | 1 = convergent rounding |
| cfg_sat_a | input | 1 | Saturation enable for accumulator A |
| cfg_sat_b | input | 1 | Saturation enable for accumulator B |
| cfg_sat_rd | input | 1 | Saturation enable for the readout |
| cfg_sat_ext | input | 1 | 1 = 40-bit limit, 0 = 32-bit limit |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | A left the 32-bit range on its last update |
| ovf_b | output | 1 | B left the 32-bit range on its last update |
| covf_a | output | 1 | A left the 40-bit range on its last update |
| covf_b | output | 1 | B left the 40-bit range on its last update |
| wb_valid | output | 1 | Readout word valid |
| wb_data | output | 16 | Rounded, optionally saturated readout |

## Verification
The assertions check every cycle that:
- the non-selected accumulator, a move and an idle cycle leave state untouched;
- a clear yields zero;
- a 32-bit-saturated accumulator never leaves that range;
- the squared and plain multiply opcodes never raise `wb_valid`;
- a 40-bit overflow always comes with a 32-bit overflow.

Only the bench scenarios can show the numeric results: signed versus unsigned extension, fractional doubling, squared difference, wrap versus clamp values, and the exact rounded word in the tie cases for both rounding modes. The bench compares these against its own integer model of each operation.

// File: rtl/mac_pkg.sv
package mac_pkg;
  parameter int OPW   = 16;
  parameter int MULW  = OPW + 1;
  parameter int PRODW = 2 * MULW;
  parameter int ACCW  = 40;
  parameter int NORMW = 32;
  parameter int RDW   = 16;
  parameter int NACC  = 2;

  typedef enum logic [2:0] {
    OP_CLR    = 3'd0,
    OP_SQD    = 3'd1,
    OP_SQDACC = 3'd2,
    OP_MAC    = 3'd3,
    OP_MSC    = 3'd4,
    OP_MPY    = 3'd5,
    OP_MPYN   = 3'd6,
    OP_MOVE   = 3'd7
  } mac_op_e;

  // Widen an operand to multiplier width, signed or unsigned.
  function automatic logic signed [MULW-1:0] widen(input logic [OPW-1:0] v, input logic sgn);
    widen = sgn ? {v[OPW-1], v} : {1'b0, v};
  endfunction

  function automatic logic writes_back(input mac_op_e op);
    writes_back = (op == OP_CLR) || (op == OP_MAC) || (op == OP_MSC) || (op == OP_MOVE);
  endfunction

  function automatic logic keeps_acc(input mac_op_e op);
    keeps_acc = (op == OP_SQDACC) || (op == OP_MAC) || (op == OP_MSC);
  endfunction

  // True when a wide value does not fit the 32-bit signed range.
  function automatic logic beyond_norm(input logic [ACCW:0] t);
    beyond_norm = !((&t[ACCW:NORMW-1]) || (~|t[ACCW:NORMW-1]));
  endfunction

  // True when a wide value does not fit the 40-bit signed range.
  function automatic logic beyond_full(input logic [ACCW:0] t);
    beyond_full = t[ACCW] ^ t[ACCW-1];
  endfunction

  function automatic logic [ACCW-1:0] clamp_acc(input logic [ACCW:0] t, input logic en,
                                                 input logic ext);
    logic [ACCW-1:0] r;
    r = t[ACCW-1:0];
    if (en && !ext && beyond_norm(t))
      r = t[ACCW] ? {{(ACCW-NORMW+1){1'b1}}, {(NORMW-1){1'b0}}}
                  : {{(ACCW-NORMW+1){1'b0}}, {(NORMW-1){1'b1}}};
    else if (en && ext && beyond_full(t))
      r = t[ACCW] ? {1'b1, {(ACCW-1){1'b0}}} : {1'b0, {(ACCW-1){1'b1}}};
    clamp_acc = r;
  endfunction

  // Round on bit 15, take bits 31:16, optionally saturate to 16 bits.
  function automatic logic [RDW-1:0] round_word(input logic [ACCW-1:0] a, input logic conv,
                                                input logic sat);
    logic [ACCW:0] inc;
    logic [ACCW:0] r;
    logic          tie;
    tie = (a[RDW-1:0] == {1'b1, {(RDW-1){1'b0}}});
    inc = (conv && tie && !a[RDW]) ? '0 : {{(ACCW-RDW+1){1'b0}}, 1'b1, {(RDW-1){1'b0}}};
    r   = {a[ACCW-1], a} + inc;
    if (sat && beyond_norm(r))
      round_word = r[ACCW] ? {1'b1, {(RDW-1){1'b0}}} : {1'b0, {(RDW-1){1'b1}}};
    else
      round_word = r[NORMW-1:NORMW-RDW];
  endfunction
endpackage

// File: rtl/mac_multiplier.sv
module mac_multiplier
  import mac_pkg::*;
(
  input  logic [OPW-1:0]  x,
  input  logic [OPW-1:0]  y,
  input  logic            sgn,
  input  logic            frac,
  input  logic            square,
  output logic [ACCW-1:0] prod
);
  logic signed [MULW-1:0]  ex, ey, diff, ma, mb;
  logic signed [PRODW-1:0] p;
  logic        [ACCW-1:0]  pwide;

  always_comb begin
    ex    = widen(x, sgn);
    ey    = widen(y, sgn);
    diff  = ex - ey;
    ma    = square ? diff : ex;
    mb    = square ? diff : ey;
    p     = ma * mb;
    pwide = {{(ACCW-PRODW){p[PRODW-1]}}, p};
    prod  = frac ? (pwide << 1) : pwide;
  end
endmodule

// File: rtl/mac_acc_slice.sv
module mac_acc_slice
  import mac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [2:0]      op,
  input  logic [ACCW-1:0] prod,
  input  logic            sat_en,
  input  logic            sat_ext,
  output logic [ACCW-1:0] acc,
  output logic            ovf,
  output logic            covf,
  output logic            clamp_hit
);
  mac_op_e       opc;
  logic [ACCW:0] base, pext, t;
  logic [ACCW-1:0] nxt;

  always_comb begin
    opc  = mac_op_e'(op);
    base = keeps_acc(opc) ? {acc[ACCW-1], acc} : '0;
    pext = {prod[ACCW-1], prod};
    case (opc)
      OP_CLR:          t = '0;
      OP_MSC, OP_MPYN: t = base - pext;
      default:         t = base + pext;
    endcase
    nxt       = clamp_acc(t, sat_en, sat_ext);
    clamp_hit = upd && (nxt != t[ACCW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      ovf  <= 1'b0;
      covf <= 1'b0;
    end else if (upd) begin
      acc  <= nxt;
      ovf  <= beyond_norm(t);
      covf <= beyond_full(t);
    end
  end
endmodule

// File: rtl/mac_readout.sv
module mac_readout
  import mac_pkg::*;
(
  input  logic [ACCW-1:0] acc,
  input  logic            conv,
  input  logic            sat,
  output logic [RDW-1:0]  word
);
  always_comb word = round_word(acc, conv, sat);
endmodule

// File: rtl/dsp_mac_engine.sv
module dsp_mac_engine
  import mac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      opcode,
  input  logic            acc_sel,
  input  logic [15:0]     x_in,
  input  logic [15:0]     y_in,
  input  logic            wb_en,
  input  logic            cfg_frac,
  input  logic            cfg_signed,
  input  logic            cfg_conv_rnd,
  input  logic            cfg_sat_a,
  input  logic            cfg_sat_b,
  input  logic            cfg_sat_rd,
  input  logic            cfg_sat_ext,
  output logic [39:0]     acc_a,
  output logic [39:0]     acc_b,
  output logic            ovf_a,
  output logic            ovf_b,
  output logic            covf_a,
  output logic            covf_b,
  output logic            wb_valid,
  output logic [15:0]     wb_data
);
  mac_op_e         opc;
  logic [ACCW-1:0] prod;
  logic            is_square;
  logic [ACCW-1:0] acc_q   [NACC];
  logic [NACC-1:0] acc_upd, ovf_q, covf_q, clamp_ev, sat_en;
  logic [ACCW-1:0] other_acc;
  logic [RDW-1:0]  rd_word;
  logic            wb_fire;

  assign opc       = mac_op_e'(opcode);
  assign is_square = (opc == OP_SQD) || (opc == OP_SQDACC);
  assign sat_en    = {cfg_sat_b, cfg_sat_a};

  mac_multiplier u_mul (
    .x(x_in), .y(y_in), .sgn(cfg_signed), .frac(cfg_frac),
    .square(is_square), .prod(prod)
  );

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    assign acc_upd[g] = op_valid && (acc_sel == g[0]) && (opc != OP_MOVE);
    mac_acc_slice u_slice (
      .clk(clk), .rst_n(rst_n), .upd(acc_upd[g]), .op(opcode), .prod(prod),
      .sat_en(sat_en[g]), .sat_ext(cfg_sat_ext), .acc(acc_q[g]),
      .ovf(ovf_q[g]), .covf(covf_q[g]), .clamp_hit(clamp_ev[g])
    );
  end

  assign other_acc = acc_sel ? acc_q[0] : acc_q[1];
  assign wb_fire   = op_valid && wb_en && writes_back(opc);

  mac_readout u_rd (
    .acc(other_acc), .conv(cfg_conv_rnd), .sat(cfg_sat_rd), .word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_data  <= '0;
    end else begin
      wb_valid <= wb_fire;
      if (wb_fire) wb_data <= rd_word;
    end
  end

  assign acc_a  = acc_q[0];
  assign acc_b  = acc_q[1];
  assign ovf_a  = ovf_q[0];
  assign ovf_b  = ovf_q[1];
  assign covf_a = covf_q[0];
  assign covf_b = covf_q[1];
endmodule

// File: rtl/mac_checker.sv
module mac_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  opcode,
  input logic        acc_sel,
  input logic        cfg_sat_a,
  input logic        cfg_sat_ext,
  input logic [39:0] acc_a,
  input logic [39:0] acc_b,
  input logic        ovf_a,
  input logic        covf_a,
  input logic        covf_b,
  input logic        ovf_b,
  input logic        wb_valid,
  input logic [1:0]  acc_upd
);
  p_clr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 3'd0 && !acc_sel) |=> (acc_a == 40'd0 && !ovf_a && !covf_a));

  p_b_untouched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !acc_sel) |=> $stable(acc_b));

  p_a_untouched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && acc_sel) |=> $stable(acc_a));

  p_move_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 3'd7) |=> ($stable(acc_a) && $stable(acc_b)));

  p_sat_norm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_upd[0] && cfg_sat_a && !cfg_sat_ext)
      |=> ((acc_a[39:31] == 9'h000) || (acc_a[39:31] == 9'h1FF)));

  p_full_implies_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (covf_a |-> ovf_a) and (covf_b |-> ovf_b));

  p_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (opcode == 3'd1 || opcode == 3'd2 || opcode == 3'd5 || opcode == 3'd6))
      |=> !wb_valid);

  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_upd));

  p_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_a) && $stable(acc_b) && !wb_valid && $stable(ovf_a)
                   && $stable(ovf_b)));
endmodule

bind dsp_mac_engine mac_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .acc_sel(acc_sel),
  .cfg_sat_a(cfg_sat_a), .cfg_sat_ext(cfg_sat_ext), .acc_a(acc_a), .acc_b(acc_b),
  .ovf_a(ovf_a), .covf_a(covf_a), .covf_b(covf_b), .ovf_b(ovf_b),
  .wb_valid(wb_valid), .acc_upd(acc_upd)
);

// File: tb/sim_dsp_mac_engine.sv
module sim_dsp_mac_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  opcode = 3'd0;
  logic        acc_sel = 1'b0;
  logic [15:0] x_in = 16'd0, y_in = 16'd0;
  logic        wb_en = 1'b0;
  logic        cfg_frac = 1'b0, cfg_signed = 1'b1, cfg_conv_rnd = 1'b0;
  logic        cfg_sat_a = 1'b0, cfg_sat_b = 1'b0, cfg_sat_rd = 1'b0, cfg_sat_ext = 1'b0;
  logic [39:0] acc_a, acc_b;
  logic        ovf_a, ovf_b, covf_a, covf_b, wb_valid;
  logic [15:0] wb_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  longint m_acc [2];
  bit     m_ovf [2];
  bit     m_covf[2];

  always #10 clk = ~clk;

  dsp_mac_engine u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .acc_sel(acc_sel),
    .x_in(x_in), .y_in(y_in), .wb_en(wb_en), .cfg_frac(cfg_frac), .cfg_signed(cfg_signed),
    .cfg_conv_rnd(cfg_conv_rnd), .cfg_sat_a(cfg_sat_a), .cfg_sat_b(cfg_sat_b),
    .cfg_sat_rd(cfg_sat_rd), .cfg_sat_ext(cfg_sat_ext), .acc_a(acc_a), .acc_b(acc_b),
    .ovf_a(ovf_a), .ovf_b(ovf_b), .covf_a(covf_a), .covf_b(covf_b),
    .wb_valid(wb_valid), .wb_data(wb_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Model arithmetic in plain integers.
  function automatic longint opnd(input logic [15:0] v);
    return cfg_signed ? longint'($signed(v)) : longint'(v);
  endfunction

  function automatic longint to40(input longint v);
    return (v <<< 24) >>> 24;
  endfunction

  function automatic longint rd_model(input longint v);
    longint lo, inc, r;
    lo  = v & 64'hFFFF;
    inc = (cfg_conv_rnd && lo == 64'h8000 && ((v >>> 16) & 1) == 0) ? 0 : 64'h8000;
    r   = v + inc;
    if (cfg_sat_rd && r > 64'sd2147483647) return 64'h7FFF;
    if (cfg_sat_rd && r < -64'sd2147483648) return 64'h8000;
    return (r >>> 16) & 64'hFFFF;
  endfunction

  function automatic void model_op(input logic [2:0] opc, input bit sel,
                                   input logic [15:0] x, input logic [15:0] y);
    longint p, d, t, hi;
    bit     sat;
    if (opc == 3'd7) return;
    if (opc == 3'd1 || opc == 3'd2) begin
      d = opnd(x) - opnd(y);
      p = d * d;
    end else p = opnd(x) * opnd(y);
    if (cfg_frac) p = p * 2;
    case (opc)
      3'd0: t = 0;
      3'd1, 3'd5: t = p;
      3'd6: t = -p;
      3'd4: t = m_acc[sel] - p;
      default: t = m_acc[sel] + p;
    endcase
    m_ovf[sel]  = (t > 64'sd2147483647) || (t < -64'sd2147483648);
    hi = 64'sd1 <<< 39;
    m_covf[sel] = (t > hi - 1) || (t < -hi);
    sat = sel ? cfg_sat_b : cfg_sat_a;
    if (sat && !cfg_sat_ext && m_ovf[sel])
      t = (t > 0) ? 64'sd2147483647 : -64'sd2147483648;
    else if (sat && cfg_sat_ext && m_covf[sel])
      t = (t > 0) ? hi - 1 : -hi;
    else t = to40(t);
    m_acc[sel] = t;
  endfunction

  task automatic compare_state(input string req);
    check(longint'($signed(acc_a)) == m_acc[0], req, "acc_a", longint'($signed(acc_a)), m_acc[0]);
    check(longint'($signed(acc_b)) == m_acc[1], req, "acc_b", longint'($signed(acc_b)), m_acc[1]);
    check({ovf_a, ovf_b, covf_a, covf_b} == {m_ovf[0], m_ovf[1], m_covf[0], m_covf[1]},
          req, "flags ovfA,ovfB,covfA,covfB", {ovf_a, ovf_b, covf_a, covf_b},
          {m_ovf[0], m_ovf[1], m_covf[0], m_covf[1]});
  endtask

  task automatic do_op(input logic [2:0] opc, input bit sel, input logic [15:0] x,
                       input logic [15:0] y, input bit wb, input string req);
    bit     exp_v;
    longint exp_d;
    @(negedge clk);
    exp_v = wb && (opc == 3'd0 || opc == 3'd3 || opc == 3'd4 || opc == 3'd7);
    exp_d = rd_model(m_acc[!sel]);
    model_op(opc, sel, x, y);
    op_valid = 1'b1; opcode = opc; acc_sel = sel; x_in = x; y_in = y; wb_en = wb;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; wb_en = 1'b0;
    compare_state(req);
    check(wb_valid == exp_v, req, "wb_valid", wb_valid, exp_v);
    if (exp_v) check(longint'(wb_data) == exp_d, req, "wb_data", longint'(wb_data), exp_d);
  endtask

  task automatic set_cfg(input bit frac, input bit sgn, input bit conv, input bit sa,
                         input bit sb, input bit srd, input bit sext);
    @(negedge clk);
    cfg_frac = frac; cfg_signed = sgn; cfg_conv_rnd = conv; cfg_sat_a = sa;
    cfg_sat_b = sb; cfg_sat_rd = srd; cfg_sat_ext = sext;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 2; i++) begin m_acc[i] = 0; m_ovf[i] = 0; m_covf[i] = 0; end
    @(negedge clk);
    compare_state("R1");
    check(wb_valid == 1'b0, "R1", "wb_valid", wb_valid, 0);
  endtask

  task automatic t_int_signed;
    set_cfg(0, 1, 0, 0, 0, 0, 0);
    do_op(3'd5, 0, 16'd3, 16'hFFFB, 0, "R3");
    do_op(3'd6, 1, 16'd3, 16'hFFFB, 0, "R3");
    do_op(3'd3, 0, 16'd100, 16'd200, 0, "R3");
    do_op(3'd4, 0, 16'd10, 16'd10, 0, "R3");
    do_op(3'd3, 1, 16'h8000, 16'h8000, 0, "R3");
    do_op(3'd7, 0, 16'd9, 16'd9, 0, "R2");
    do_op(3'd0, 1, 16'd5, 16'd5, 0, "R2");
  endtask

  task automatic t_unsigned;
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    do_op(3'd5, 0, 16'hFFFF, 16'd2, 0, "R4");
    do_op(3'd5, 1, 16'h8000, 16'h8000, 0, "R4");
    set_cfg(0, 1, 0, 0, 0, 0, 0);
    do_op(3'd5, 0, 16'hFFFF, 16'd2, 0, "R4");
  endtask

  task automatic t_frac;
    set_cfg(1, 1, 0, 0, 0, 0, 0);
    do_op(3'd5, 0, 16'h4000, 16'h4000, 0, "R5");
    do_op(3'd3, 0, 16'h8000, 16'h4000, 0, "R5");
    do_op(3'd6, 1, 16'h7FFF, 16'h0003, 0, "R5");
  endtask

  task automatic t_sqdiff;
    set_cfg(0, 1, 0, 0, 0, 0, 0);
    do_op(3'd1, 0, 16'd10, 16'd3, 0, "R6");
    do_op(3'd2, 0, 16'd5, 16'd9, 0, "R6");
    do_op(3'd1, 1, 16'h8000, 16'h7FFF, 0, "R6");
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    do_op(3'd2, 1, 16'd0, 16'hFFFF, 0, "R6");
  endtask

  task automatic t_sat_norm;
    set_cfg(0, 1, 0, 1, 0, 0, 0);
    do_op(3'd5, 0, 16'h7FFF, 16'h7FFF, 0, "R7");
    for (int i = 0; i < 3; i++) do_op(3'd3, 0, 16'h7FFF, 16'h7FFF, 0, "R7");
    do_op(3'd5, 1, 16'h7FFF, 16'h7FFF, 0, "R7");
    for (int i = 0; i < 3; i++) do_op(3'd3, 1, 16'h7FFF, 16'h7FFF, 0, "R7");
    do_op(3'd6, 0, 16'h7FFF, 16'h7FFF, 0, "R7");
    for (int i = 0; i < 3; i++) do_op(3'd4, 0, 16'h7FFF, 16'h7FFF, 0, "R7");
  endtask

  task automatic t_sat_ext;
    set_cfg(1, 0, 0, 0, 1, 0, 1);
    do_op(3'd5, 1, 16'hFFFF, 16'hFFFF, 0, "R8");
    do_op(3'd5, 0, 16'hFFFF, 16'hFFFF, 0, "R8");
    for (int i = 0; i < 70; i++) do_op(3'd3, 1, 16'hFFFF, 16'hFFFF, 0, "R8");
    for (int i = 0; i < 70; i++) do_op(3'd3, 0, 16'hFFFF, 16'hFFFF, 0, "R8");
  endtask

  task automatic t_writeback;
    set_cfg(0, 1, 0, 0, 0, 0, 0);
    do_op(3'd5, 0, 16'd300, 16'd700, 0, "R9");
    do_op(3'd5, 1, 16'h7000, 16'h0100, 0, "R9");
    do_op(3'd3, 0, 16'd1, 16'd1, 1, "R9");
    do_op(3'd4, 1, 16'd1, 16'd1, 1, "R9");
    do_op(3'd7, 0, 16'd0, 16'd0, 1, "R9");
    do_op(3'd5, 0, 16'd2, 16'd2, 1, "R9");
    do_op(3'd6, 1, 16'd2, 16'd2, 1, "R9");
    do_op(3'd1, 0, 16'd2, 16'd1, 1, "R9");
    do_op(3'd2, 1, 16'd2, 16'd1, 1, "R9");
    do_op(3'd0, 0, 16'd0, 16'd0, 1, "R9");
  endtask

  task automatic t_rounding;
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    do_op(3'd5, 0, 16'd1, 16'h8000, 0, "R10");
    do_op(3'd7, 1, 16'd0, 16'd0, 1, "R10");
    do_op(3'd5, 0, 16'd3, 16'h8000, 0, "R10");
    do_op(3'd7, 1, 16'd0, 16'd0, 1, "R10");
    do_op(3'd5, 0, 16'd1, 16'h7FFF, 0, "R10");
    do_op(3'd7, 1, 16'd0, 16'd0, 1, "R10");
    set_cfg(0, 0, 1, 0, 0, 0, 0);
    do_op(3'd5, 0, 16'd1, 16'h8000, 0, "R11");
    do_op(3'd7, 1, 16'd0, 16'd0, 1, "R11");
    do_op(3'd5, 0, 16'd3, 16'h8000, 0, "R11");
    do_op(3'd7, 1, 16'd0, 16'd0, 1, "R11");
    do_op(3'd5, 0, 16'd1, 16'h8001, 0, "R11");
    do_op(3'd7, 1, 16'd0, 16'd0, 1, "R11");
  endtask

  task automatic t_read_sat;
    set_cfg(0, 1, 0, 0, 0, 1, 0);
    do_op(3'd5, 0, 16'h7FFF, 16'h7FFF, 0, "R12");
    for (int i = 0; i < 3; i++) do_op(3'd3, 0, 16'h7FFF, 16'h7FFF, 0, "R12");
    do_op(3'd7, 1, 16'd0, 16'd0, 1, "R12");
    set_cfg(0, 1, 0, 0, 0, 0, 0);
    do_op(3'd7, 1, 16'd0, 16'd0, 1, "R12");
    set_cfg(0, 1, 0, 0, 0, 1, 0);
    do_op(3'd6, 1, 16'h7FFF, 16'h7FFF, 0, "R12");
    for (int i = 0; i < 3; i++) do_op(3'd4, 1, 16'h7FFF, 16'h7FFF, 0, "R12");
    do_op(3'd7, 0, 16'd0, 16'd0, 1, "R12");
  endtask

  task automatic t_idle;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      opcode = 3'(i); acc_sel = i[0]; x_in = 16'h1234 + 16'(i); y_in = 16'h7777;
      wb_en = 1'b1; op_valid = 1'b0;
      @(negedge clk);
      compare_state("R13");
      check(wb_valid == 1'b0, "R13", "wb_valid", wb_valid, 0);
    end
    wb_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_int_signed;
    t_unsigned;
    t_frac;
    t_sqdiff;
    t_sat_norm;
    t_sat_ext;
    t_writeback;
    t_rounding;
    t_read_sat;
    t_idle;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule